// File: doc/BRIEF.md
# Keyed Watchdog Timer with Early-Warning Interrupt

This block is a watchdog for a system bus. It counts down a 15-bit timeout in units of one slow tick, nominally 10 ms. The slow tick arrives as a free-running level input from a separate clock. The block synchronises it into the system clock and counts one step on each rising edge. When the count is exhausted, the block first raises a maskable early-warning event. One tick later it asserts a sticky system reset request.

Software controls the timer through a small register bus. Feeding, resuming, clearing the timed-out status and disabling each take effect only when a specific 16-bit key value is written. Disabling needs two keyed writes, made in order, to two different registers. The count readback carries a flag in bit 15. The flag marks that a tick edge is still crossing into the system clock, so software re-reads until the flag is clear.

The timer leaves reset disabled. A debug input can freeze counting unless software has allowed the watchdog to run in debug mode. Register reads are combinational from the address. Writes take effect on the rising clock edge where `bus_we` is high. The bus has no handshake: every access completes in one cycle and cannot be back-pressured.

Top module: `keyed_wdt`

## Requirements
- R1: After reset the timer is disabled, so offset 0x0C reads 0xDABE. The count at 0x14 reads 0, the status at 0x10 reads 0x0000, `irq_o` and `wdt_rst_o` are low, and the timeout at 0x04 reads the parameter default (6000).
- R2: The timeout register at 0x04 stores only bits 14:0 of a write, so writing 0xFFFF reads back 0x7FFF.
- R3: Writing 0xFEED to 0x00 reloads the count from the timeout register and clears the warning stage. Any other value written to 0x00 changes nothing.
- R4: At 0x14, bits 14:0 give the remaining count. Bit 15 is 1 from the first system clock edge after `tick_i` rises until the count has taken that tick, which is two edges later. Otherwise bit 15 is 0.
- R5: While enabled and not frozen, each rising edge of `tick_i` lowers a nonzero count by one. The count changes on the third system clock edge after the rise. It never rises except on a feed.
- R6: The first tick that finds the count at zero sets the event bit (bit 0 at 0x20). The next tick asserts `wdt_rst_o`, and the status at 0x10 then reads 0xCFE8.
- R7: Writing 1 to bit 0 of 0x20 acknowledges the event. The event bit clears at the next tick edge, not before.
- R8: `irq_o` is high only while mask bit 0 at 0x24 is 1 and either the event is set or force bit 0 at 0x28 is 1. Bit 0 of 0x20 reads event OR force.
- R9: Writing 0x2BAD to 0x08 and then 0xCAFE to 0x0C disables the timer. Any write to 0x0C, and any non-key write to 0x08, drops a partial unlock. While disabled, ticks do not change the count, and 0x0C reads 0xDABE; while enabled it reads 0x0000.
- R10: Writing 0xACED to 0x1C while disabled re-enables the timer without reloading the count. Other values written there are ignored.
- R11: At 0x18, bit 1 reads the `dbg_mode_i` input and bit 0 is read/write. While `dbg_mode_i` is 1 and bit 0 is 0, ticks do not change the count.
- R12: Writing 0xE8B4 to 0x10 clears the timed-out status, drops `wdt_rst_o` and re-arms the warning stage. `wdt_rst_o` otherwise stays high once set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Slow tick clock level, sampled asynchronously |
| dbg_mode_i | input | 1 | Debug mode indicator |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| irq_o | output | 1 | Early-warning interrupt |
| wdt_rst_o | output | 1 | System reset request |

## Verification
The hardest state to reach is the expired state in which an acknowledge is still pending. To get there, the bench must first let the count run down to zero, then take the warning tick, then write the acknowledge. Only after that does it drive the one tick that both clears the event and fires the reset. The bench steps `tick_i` by hand through a short timeout and reads the registers between ticks. The in-flight flag is caught the same way: the bench raises `tick_i` and reads the count after exactly one system clock edge.

// File: rtl/keyed_wdt_pkg.sv
package keyed_wdt_pkg;
  // Key values written by software
  localparam logic [15:0] KEY_FEED    = 16'hFEED;
  localparam logic [15:0] KEY_UNLOCK1 = 16'h2BAD;
  localparam logic [15:0] KEY_UNLOCK2 = 16'hCAFE;
  localparam logic [15:0] KEY_RESUME  = 16'hACED;
  localparam logic [15:0] KEY_STS_CLR = 16'hE8B4;
  // Readback codes
  localparam logic [15:0] CODE_OFF    = 16'hDABE;
  localparam logic [15:0] CODE_ON     = 16'h0000;
  localparam logic [15:0] CODE_BARKED = 16'hCFE8;
  // Byte offsets
  localparam logic [7:0] OFS_FEED  = 8'h00;
  localparam logic [7:0] OFS_TMO   = 8'h04;
  localparam logic [7:0] OFS_LOCK1 = 8'h08;
  localparam logic [7:0] OFS_LOCK2 = 8'h0C;
  localparam logic [7:0] OFS_STAT  = 8'h10;
  localparam logic [7:0] OFS_CNT   = 8'h14;
  localparam logic [7:0] OFS_DBG   = 8'h18;
  localparam logic [7:0] OFS_RSUM  = 8'h1C;
  localparam logic [7:0] OFS_EVT   = 8'h20;
  localparam logic [7:0] OFS_MASK  = 8'h24;
  localparam logic [7:0] OFS_FORCE = 8'h28;
endpackage

// File: rtl/keyed_wdt_tick_sync.sv
module keyed_wdt_tick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  output logic edge_o,
  output logic inflight_o
);
  localparam int LAST = STAGES;

  logic [LAST:0] sync_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[LAST-1:0], tick_i};
  end

  // A rising edge sits somewhere in the chain until it reaches the last stage
  assign edge_o     = sync_q[LAST-1] & ~sync_q[LAST];
  assign inflight_o = |(sync_q[LAST-1:0] & ~sync_q[LAST:1]);
endmodule

// File: rtl/keyed_wdt_counter.sv
module keyed_wdt_counter #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             feed,
  input  logic             ack,
  input  logic             clr,
  input  logic             en,
  input  logic             frozen,
  input  logic [CNT_W-1:0] tmo,
  output logic [CNT_W-1:0] cnt_o,
  output logic             evt_o,
  output logic             warned_o,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;
  logic evt_q, warned_q, expired_q, ack_pend_q;
  logic step;

  assign step = tick && en && !frozen && !expired_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      evt_q      <= 1'b0;
      warned_q   <= 1'b0;
      expired_q  <= 1'b0;
      ack_pend_q <= 1'b0;
    end else begin
      // acknowledge lands at the next slow tick
      if (tick && ack_pend_q) begin
        evt_q      <= 1'b0;
        ack_pend_q <= 1'b0;
      end
      if (ack) ack_pend_q <= 1'b1;
      if (clr) begin
        expired_q <= 1'b0;
        warned_q  <= 1'b0;
      end
      if (feed) begin
        cnt_q    <= tmo;
        warned_q <= 1'b0;
      end else if (step) begin
        if (cnt_q != '0) begin
          cnt_q <= cnt_q - 1'b1;
        end else if (!warned_q) begin
          warned_q <= 1'b1;
          evt_q    <= 1'b1;
        end else begin
          expired_q <= 1'b1;
        end
      end
    end
  end

  assign cnt_o     = cnt_q;
  assign evt_o     = evt_q;
  assign warned_o  = warned_q;
  assign expired_o = expired_q;
endmodule

// File: rtl/keyed_wdt_regs.sv
module keyed_wdt_regs
  import keyed_wdt_pkg::*;
#(
  parameter int          ADDR_W  = 6,
  parameter int          CNT_W   = 15,
  parameter int unsigned TMO_RST = 6000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  input  logic              dbg_mode_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              inflight_i,
  input  logic              evt_i,
  input  logic              expired_i,
  output logic [CNT_W-1:0]  tmo_o,
  output logic              feed_o,
  output logic              ack_o,
  output logic              clr_o,
  output logic              en_o,
  output logic              frozen_o,
  output logic              mask_o,
  output logic              force_o
);
  logic [CNT_W-1:0] tmo_q;
  logic en_q, unlock_q, mask_q, force_q, dbgen_q;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
    return a == ADDR_W'(ofs);
  endfunction

  assign feed_o   = bus_we && hit(bus_addr, OFS_FEED) && bus_wdata == KEY_FEED;
  assign ack_o    = bus_we && hit(bus_addr, OFS_EVT) && bus_wdata[0];
  assign clr_o    = bus_we && hit(bus_addr, OFS_STAT) && bus_wdata == KEY_STS_CLR;
  assign frozen_o = dbg_mode_i && !dbgen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmo_q    <= CNT_W'(TMO_RST);
      en_q     <= 1'b0;
      unlock_q <= 1'b0;
      mask_q   <= 1'b0;
      force_q  <= 1'b0;
      dbgen_q  <= 1'b0;
    end else if (bus_we) begin
      if (hit(bus_addr, OFS_TMO))   tmo_q    <= bus_wdata[CNT_W-1:0];
      if (hit(bus_addr, OFS_LOCK1)) unlock_q <= (bus_wdata == KEY_UNLOCK1);
      if (hit(bus_addr, OFS_LOCK2)) begin
        unlock_q <= 1'b0;
        if (unlock_q && bus_wdata == KEY_UNLOCK2) en_q <= 1'b0;
      end
      if (hit(bus_addr, OFS_RSUM) && !en_q && bus_wdata == KEY_RESUME) en_q <= 1'b1;
      if (hit(bus_addr, OFS_MASK))  mask_q  <= bus_wdata[0];
      if (hit(bus_addr, OFS_FORCE)) force_q <= bus_wdata[0];
      if (hit(bus_addr, OFS_DBG))   dbgen_q <= bus_wdata[0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit(bus_addr, OFS_TMO))   bus_rdata = 16'(tmo_q);
    if (hit(bus_addr, OFS_LOCK2)) bus_rdata = en_q ? CODE_ON : CODE_OFF;
    if (hit(bus_addr, OFS_STAT))  bus_rdata = expired_i ? CODE_BARKED : 16'h0000;
    if (hit(bus_addr, OFS_CNT)) begin
      bus_rdata     = 16'(cnt_i);
      bus_rdata[15] = inflight_i;
    end
    if (hit(bus_addr, OFS_DBG))   bus_rdata = {14'd0, dbg_mode_i, dbgen_q};
    if (hit(bus_addr, OFS_EVT))   bus_rdata = {15'd0, evt_i | force_q};
    if (hit(bus_addr, OFS_MASK))  bus_rdata = {15'd0, mask_q};
    if (hit(bus_addr, OFS_FORCE)) bus_rdata = {15'd0, force_q};
  end

  assign tmo_o   = tmo_q;
  assign en_o    = en_q;
  assign mask_o  = mask_q;
  assign force_o = force_q;
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt #(
  parameter int          ADDR_W      = 6,
  parameter int          CNT_W       = 15,
  parameter int          SYNC_STAGES = 2,
  parameter int unsigned TMO_RST     = 6000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              dbg_mode_i,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              irq_o,
  output logic              wdt_rst_o
);
  logic tick_w, inflight_w, feed_w, ack_w, clr_w, en_w, frozen_w;
  logic mask_w, force_w, evt_w, warned_w, expired_w;
  logic [CNT_W-1:0] tmo_w, cnt_w;

  keyed_wdt_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .edge_o(tick_w), .inflight_o(inflight_w)
  );

  keyed_wdt_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .TMO_RST(TMO_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dbg_mode_i(dbg_mode_i),
    .cnt_i(cnt_w), .inflight_i(inflight_w), .evt_i(evt_w), .expired_i(expired_w),
    .tmo_o(tmo_w), .feed_o(feed_w), .ack_o(ack_w), .clr_o(clr_w), .en_o(en_w),
    .frozen_o(frozen_w), .mask_o(mask_w), .force_o(force_w)
  );

  keyed_wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick_w), .feed(feed_w), .ack(ack_w),
    .clr(clr_w), .en(en_w), .frozen(frozen_w), .tmo(tmo_w),
    .cnt_o(cnt_w), .evt_o(evt_w), .warned_o(warned_w), .expired_o(expired_w)
  );

  assign irq_o     = mask_w & (evt_w | force_w);
  assign wdt_rst_o = expired_w;
endmodule

// File: rtl/keyed_wdt_chk.sv
module keyed_wdt_chk #(
  parameter int CNT_W = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_w,
  input logic             feed_w,
  input logic             clr_w,
  input logic             mask_w,
  input logic             warned_w,
  input logic [CNT_W-1:0] cnt_w,
  input logic [CNT_W-1:0] tmo_w,
  input logic             irq_o,
  input logic             wdt_rst_o
);
  // R9
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_w && !feed_w) |=> $stable(cnt_w));
  // R5
  no_count_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !feed_w |=> (cnt_w <= $past(cnt_w)));
  // R3
  feed_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    feed_w |=> (cnt_w == $past(tmo_w)));
  // R6
  bark_after_warn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_rst_o) |-> $past(warned_w));
  // R12
  rst_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_rst_o && !clr_w) |=> wdt_rst_o);
  // R8
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_w |-> !irq_o);
endmodule

bind keyed_wdt keyed_wdt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_w(en_w), .feed_w(feed_w), .clr_w(clr_w),
  .mask_w(mask_w), .warned_w(warned_w), .cnt_w(cnt_w), .tmo_w(tmo_w),
  .irq_o(irq_o), .wdt_rst_o(wdt_rst_o)
);

// File: tb/keyed_wdt_tb.sv
module keyed_wdt_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_i = 1'b0;
  logic dbg_mode_i = 1'b0;
  logic bus_we = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic irq_o, wdt_rst_o;
  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  keyed_wdt u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .dbg_mode_i(dbg_mode_i),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o), .wdt_rst_o(wdt_rst_o)
  );

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [5:0] a, input logic [15:0] exp);
    @(negedge clk);
    bus_addr = a;
    #1;
    check(tag, bus_rdata, exp);
  endtask

  task automatic tick_pulse();
    @(negedge clk); tick_i = 1'b1;
    repeat (4) @(negedge clk);
    tick_i = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    rd_chk("R1 disabled", 6'h0C, 16'hDABE);
    rd_chk("R1 count", 6'h14, 16'h0000);
    rd_chk("R1 status", 6'h10, 16'h0000);
    rd_chk("R1 timeout", 6'h04, 16'd6000);
    check("R1 rst", {15'd0, wdt_rst_o}, 16'd0);
    check("R1 irq", {15'd0, irq_o}, 16'd0);
  endtask

  task automatic t_timeout_feed();
    wr(6'h04, 16'hFFFF);
    rd_chk("R2 mask", 6'h04, 16'h7FFF);
    wr(6'h04, 16'd3);
    wr(6'h00, 16'h1234);
    rd_chk("R3 bad key", 6'h14, 16'h0000);
    wr(6'h00, 16'hFEED);
    rd_chk("R3 reload", 6'h14, 16'h0003);
  endtask

  task automatic t_resume();
    tick_pulse();
    rd_chk("R9 off no count", 6'h14, 16'h0003);
    wr(6'h1C, 16'h1111);
    rd_chk("R10 bad key", 6'h0C, 16'hDABE);
    wr(6'h1C, 16'hACED);
    rd_chk("R10 enabled", 6'h0C, 16'h0000);
    rd_chk("R10 no reload", 6'h14, 16'h0003);
  endtask

  task automatic t_count();
    bus_addr = 6'h14;
    @(negedge clk); tick_i = 1'b1;
    @(negedge clk); #1;
    check("R4 in flight", bus_rdata, 16'h8003);
    repeat (2) @(negedge clk); #1;
    check("R5 decrement", bus_rdata, 16'h0002);
    repeat (2) @(negedge clk);
    tick_i = 1'b0;
    repeat (4) @(negedge clk); #1;
    check("R4 stable", bus_rdata, 16'h0002);
  endtask

  task automatic t_bark();
    wr(6'h24, 16'h0001);
    tick_pulse();
    tick_pulse();
    rd_chk("R5 at zero", 6'h14, 16'h0000);
    rd_chk("R6 no event yet", 6'h20, 16'h0000);
    tick_pulse();
    rd_chk("R6 event", 6'h20, 16'h0001);
    check("R8 irq", {15'd0, irq_o}, 16'd1);
    check("R6 no rst yet", {15'd0, wdt_rst_o}, 16'd0);
    wr(6'h20, 16'h0001);
    rd_chk("R7 ack pending", 6'h20, 16'h0001);
    tick_pulse();
    rd_chk("R7 ack applied", 6'h20, 16'h0000);
    check("R6 rst", {15'd0, wdt_rst_o}, 16'd1);
    rd_chk("R6 status", 6'h10, 16'hCFE8);
    wr(6'h10, 16'h1234);
    check("R12 sticky", {15'd0, wdt_rst_o}, 16'd1);
    wr(6'h10, 16'hE8B4);
    rd_chk("R12 status clr", 6'h10, 16'h0000);
    check("R12 rst clr", {15'd0, wdt_rst_o}, 16'd0);
    wr(6'h00, 16'hFEED);
    rd_chk("R3 refeed", 6'h14, 16'h0003);
  endtask

  task automatic t_disable();
    wr(6'h0C, 16'hCAFE);
    rd_chk("R9 lone key2", 6'h0C, 16'h0000);
    wr(6'h08, 16'h2BAD);
    wr(6'h0C, 16'h1234);
    wr(6'h0C, 16'hCAFE);
    rd_chk("R9 broken seq", 6'h0C, 16'h0000);
    wr(6'h08, 16'h2BAD);
    wr(6'h0C, 16'hCAFE);
    rd_chk("R9 disabled", 6'h0C, 16'hDABE);
    tick_pulse();
    rd_chk("R9 halted", 6'h14, 16'h0003);
    wr(6'h1C, 16'hACED);
  endtask

  task automatic t_debug();
    dbg_mode_i = 1'b1;
    rd_chk("R11 mode bit", 6'h18, 16'h0002);
    tick_pulse();
    rd_chk("R11 frozen", 6'h14, 16'h0003);
    wr(6'h18, 16'h0001);
    rd_chk("R11 enable bit", 6'h18, 16'h0003);
    tick_pulse();
    rd_chk("R11 runs", 6'h14, 16'h0002);
    dbg_mode_i = 1'b0;
  endtask

  task automatic t_force();
    wr(6'h24, 16'h0000);
    wr(6'h28, 16'h0001);
    rd_chk("R8 forced evt", 6'h20, 16'h0001);
    check("R8 masked", {15'd0, irq_o}, 16'd0);
    wr(6'h24, 16'h0001);
    #1 check("R8 forced irq", {15'd0, irq_o}, 16'd1);
    wr(6'h28, 16'h0000);
    #1 check("R8 unforced", {15'd0, irq_o}, 16'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_timeout_feed();
    t_resume();
    t_count();
    t_bark();
    t_disable();
    t_debug();
    t_force();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule